// File: doc/BRIEF.md
# Multi-Source Trigger Detector

This block turns one of several trigger sources into a single-cycle start pulse for an acquisition engine. There are six candidate sources. The first is a synchronous software strobe. The second is a front-panel digital input. The third is a level-crossing test on the sampled data of one of four analog channels. The last three are any line of an 8-bit backplane trigger bus, a star line and a differential star line. The asynchronous digital lines pass through a synchronizer before detection. After that they are edge-detected with a configurable polarity, and a pulse that lasts fewer than a minimum number of clock cycles is thrown away.

Software configures the source, polarity, analog channel, bus line and trigger level while `arm` is low. Raising `arm` freezes that choice, and every qualifying event then produces one `trig_pulse`. In master mode the accepted pulse is also driven onto one chosen bit of the trigger bus. That bit's enable stays asserted for as long as master mode is configured.

Top module: `trig_detect`

## Requirements
- R1: While reset is asserted, `trig_pulse`, `bus_out` and `bus_oe` are all zero.
- R2: `src_sel` encodes the source as 0 = software strobe, 1 = front-panel input, 2 = analog channel, 3 = trigger bus line, 4 = star line, 5 = differential star line. Codes 6 to 15 never produce a trigger, whatever the inputs do.
- R3: With source 0 and `arm` high, a rising edge of `sw_strobe` gives exactly one `trig_pulse`, in the cycle after the edge is sampled. Holding the strobe high gives no further pulses.
- R4: With `falling_edge` = 0, a digital source (codes 1, 3, 4, 5) fires when its line goes from low to high and stays high for at least MIN_WIDTH (default 2) clock cycles. For a rising input driven between two clock edges, `trig_pulse` is high in the fourth cycle after the change: two synchronizer flops, one width cycle and the output register.
- R5: With `falling_edge` = 1, the digital sources fire on a high-to-low change that stays low for at least MIN_WIDTH cycles.
- R6: A digital pulse shorter than MIN_WIDTH cycles gives no trigger. A line that is already at its active level when the block is armed gives no trigger until it has returned to its idle level.
- R7: `trig_pulse` is never high for two consecutive cycles. One qualifying event gives one pulse, however long the active level is held.
- R8: With source 2 and `falling_edge` = 0, a valid sample fires when the selected channel's previous valid sample is below `trig_level` and the current one is at or above it. Samples and level are compared as signed two's complement. Channel n occupies `ain_data[16n+15:16n]`. The pulse appears in the cycle after the `ain_valid` cycle, and the other channels have no effect.
- R9: With source 2 and `falling_edge` = 1, a valid sample fires when the previous sample is at or above `trig_level` and the current one is below it. The comparison is signed.
- R10: The first valid analog sample after arming never fires, because no previous sample from the armed period exists yet. Samples presented while disarmed are not remembered.
- R11: When master mode is configured, `bus_oe` has only bit `drive_sel` set, and `bus_out` carries `trig_pulse` on that bit and zero elsewhere. Without master mode both are zero.
- R12: Changes to `src_sel`, `falling_edge`, `ain_sel`, `line_sel`, `master_en` and `drive_sel` take effect only while `arm` is low. While `arm` is low no trigger is produced.
- R13: Source 3 uses bus line `line_sel`, and sources 4 and 5 use the star and differential star inputs. These lines follow the same polarity and width rules as the front-panel input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | High: detect triggers with the frozen configuration; low: accept new configuration |
| src_sel | input | 4 | Source code (see R2) |
| falling_edge | input | 1 | 0 = rising, 1 = falling, for digital and analog sources |
| ain_sel | input | 2 | Analog channel used by source 2 |
| line_sel | input | 3 | Trigger bus line used by source 3 |
| master_en | input | 1 | Drive accepted triggers onto the bus |
| drive_sel | input | 3 | Bus bit driven in master mode |
| sw_strobe | input | 1 | Synchronous software trigger |
| ext_trig | input | 1 | Asynchronous front-panel trigger input |
| bus_in | input | 8 | Asynchronous trigger bus lines |
| star_trig | input | 1 | Asynchronous star trigger |
| dstar_trig | input | 1 | Asynchronous differential star trigger (already received) |
| ain_valid | input | 1 | Sample strobe for `ain_data` |
| ain_data | input | 64 | Four signed 16-bit samples, channel 0 in the low bits |
| trig_level | input | 16 | Signed analog trigger threshold |
| trig_pulse | output | 1 | One-cycle trigger to the acquisition engine |
| bus_out | output | 8 | Trigger bus drive data |
| bus_oe | output | 8 | Trigger bus drive enables |

## Verification
The selected trigger source and a configuration write can land in the same cycle. The bench provokes this by changing `src_sel` while armed and then pulsing both the new source and the frozen one. Only the frozen source may produce a pulse, and the pulse count for each must be exact. The other overlap is the trigger pulse and the master bus drive. The bench checks in the very cycle `trig_pulse` rises that only the selected bus bit carries it, and that the bit is clear in the cycle after.

// File: rtl/trig_detect.sv
module trig_detect #(
  parameter int SAMPLE_W    = 16,
  parameter int NUM_AIN     = 4,
  parameter int BUS_W       = 8,
  parameter int MIN_WIDTH   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm,
  input  logic [3:0]                    src_sel,
  input  logic                          falling_edge,
  input  logic [$clog2(NUM_AIN)-1:0]    ain_sel,
  input  logic [$clog2(BUS_W)-1:0]      line_sel,
  input  logic                          master_en,
  input  logic [$clog2(BUS_W)-1:0]      drive_sel,
  input  logic                          sw_strobe,
  input  logic                          ext_trig,
  input  logic [BUS_W-1:0]              bus_in,
  input  logic                          star_trig,
  input  logic                          dstar_trig,
  input  logic                          ain_valid,
  input  logic [NUM_AIN*SAMPLE_W-1:0]   ain_data,
  input  logic signed [SAMPLE_W-1:0]    trig_level,
  output logic                          trig_pulse,
  output logic [BUS_W-1:0]              bus_out,
  output logic [BUS_W-1:0]              bus_oe
);

  localparam int CH_W    = $clog2(NUM_AIN);
  localparam int LINE_W  = $clog2(BUS_W);
  localparam int CNT_W   = $clog2(MIN_WIDTH + 1);
  localparam int NUM_DIG = BUS_W + 3;
  localparam int IDX_EXT = BUS_W;
  localparam int IDX_STR = BUS_W + 1;
  localparam int IDX_DST = BUS_W + 2;

  localparam logic [3:0] SRC_SW    = 4'd0;
  localparam logic [3:0] SRC_EXT   = 4'd1;
  localparam logic [3:0] SRC_AIN   = 4'd2;
  localparam logic [3:0] SRC_BUS   = 4'd3;
  localparam logic [3:0] SRC_STAR  = 4'd4;
  localparam logic [3:0] SRC_DSTAR = 4'd5;
  localparam logic [3:0] SRC_OFF   = 4'hF;

  logic [3:0]        cfg_src;
  logic              cfg_fall;
  logic [CH_W-1:0]   cfg_ch;
  logic [LINE_W-1:0] cfg_line;
  logic              cfg_master;
  logic [LINE_W-1:0] cfg_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_src    <= SRC_OFF;
      cfg_fall   <= 1'b0;
      cfg_ch     <= '0;
      cfg_line   <= '0;
      cfg_master <= 1'b0;
      cfg_drive  <= '0;
    end else if (!arm) begin
      cfg_src    <= src_sel;
      cfg_fall   <= falling_edge;
      cfg_ch     <= ain_sel;
      cfg_line   <= line_sel;
      cfg_master <= master_en;
      cfg_drive  <= drive_sel;
    end
  end

  // Synchronizer for every asynchronous line
  logic [NUM_DIG-1:0] dig_raw;
  logic [NUM_DIG-1:0] sync_q [SYNC_STAGES];
  assign dig_raw = {dstar_trig, star_trig, ext_trig, bus_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= dig_raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  logic [NUM_DIG-1:0] dig;
  logic               dig_sel, is_dig, dig_act;
  assign dig = sync_q[SYNC_STAGES-1];

  always_comb begin
    is_dig  = 1'b1;
    dig_sel = 1'b0;
    case (cfg_src)
      SRC_EXT:   dig_sel = dig[IDX_EXT];
      SRC_BUS:   dig_sel = dig[cfg_line];
      SRC_STAR:  dig_sel = dig[IDX_STR];
      SRC_DSTAR: dig_sel = dig[IDX_DST];
      default:   is_dig  = 1'b0;
    endcase
  end

  assign dig_act = dig_sel ^ cfg_fall;

  // Width qualifier: counts active cycles after an idle level was seen
  logic [CNT_W-1:0] wcnt;
  logic             idle_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt      <= '0;
      idle_seen <= 1'b0;
    end else if (!arm || !is_dig) begin
      wcnt      <= '0;
      idle_seen <= 1'b0;
    end else if (!dig_act) begin
      wcnt      <= '0;
      idle_seen <= 1'b1;
    end else if (idle_seen && wcnt != CNT_W'(MIN_WIDTH)) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  logic dig_fire;
  assign dig_fire = arm && is_dig && dig_act && idle_seen && (wcnt == CNT_W'(MIN_WIDTH - 1));

  // Software strobe
  logic sw_prev, sw_fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_prev <= 1'b0;
    else        sw_prev <= sw_strobe;
  end
  assign sw_fire = arm && (cfg_src == SRC_SW) && sw_strobe && !sw_prev;

  // Analog level crossing
  logic signed [SAMPLE_W-1:0] cur_smp, prev_smp;
  logic                       prev_ok, cur_hi, prev_hi, ain_fire;

  assign cur_smp = ain_data[int'(cfg_ch)*SAMPLE_W +: SAMPLE_W];
  assign cur_hi  = cur_smp >= trig_level;
  assign prev_hi = prev_smp >= trig_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_smp <= '0;
      prev_ok  <= 1'b0;
    end else if (!arm || cfg_src != SRC_AIN) begin
      prev_ok  <= 1'b0;
    end else if (ain_valid) begin
      prev_smp <= cur_smp;
      prev_ok  <= 1'b1;
    end
  end

  assign ain_fire = arm && (cfg_src == SRC_AIN) && ain_valid && prev_ok &&
                    (cfg_fall ? (prev_hi && !cur_hi) : (!prev_hi && cur_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_pulse <= 1'b0;
    else        trig_pulse <= sw_fire || dig_fire || ain_fire;
  end

  assign bus_oe  = cfg_master ? (BUS_W'(1) << cfg_drive) : '0;
  assign bus_out = bus_oe & {BUS_W{trig_pulse}};

  // R7: one pulse never stretches
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R12: disarmed means silent
  p_quiet_disarmed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !trig_pulse);

  // R12: configuration frozen while armed
  p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> ($stable(cfg_src) && $stable(cfg_fall) && $stable(cfg_ch) && $stable(cfg_line)));

  // R3: a software trigger needs the strobe
  p_sw_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && cfg_src == SRC_SW) |-> $past(sw_strobe));

  // R8: an analog trigger needs a valid sample
  p_ain_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && cfg_src == SRC_AIN) |-> $past(ain_valid));

  // R2: unused codes stay silent
  p_unused_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (cfg_src <= SRC_DSTAR));

  // R11: at most one bus bit enabled
  p_oe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_oe));

endmodule

// File: tb/trig_detect_test.sv
`timescale 1ns/1ps
module trig_detect_test;
  localparam int CLK_PERIOD = 12;
  localparam int NVEC = 12;
  // {src[3:0], pol, line[2:0], len[3:0], expected pulses[3:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h1010, 16'h1021, 16'h1061, 16'h1831, 16'h1810, 16'h3521,
    16'h3841, 16'h4031, 16'h5821, 16'h7050, 16'hF050, 16'h3710
  };

  logic clk = 0, rst_n = 0, arm = 0;
  logic [3:0] src_sel = 0;
  logic falling_edge = 0, master_en = 0;
  logic [1:0] ain_sel = 0;
  logic [2:0] line_sel = 0, drive_sel = 0;
  logic sw_strobe = 0, ext_trig = 0, star_trig = 0, dstar_trig = 0, ain_valid = 0;
  logic [7:0] bus_in = 0;
  logic [63:0] ain_data = 0;
  logic signed [15:0] trig_level = 0;
  logic trig_pulse;
  logic [7:0] bus_out, bus_oe;

  int n_checks = 0, n_fail = 0, pulse_cnt = 0;

  trig_detect uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .src_sel(src_sel), .falling_edge(falling_edge),
    .ain_sel(ain_sel), .line_sel(line_sel), .master_en(master_en), .drive_sel(drive_sel),
    .sw_strobe(sw_strobe), .ext_trig(ext_trig), .bus_in(bus_in), .star_trig(star_trig),
    .dstar_trig(dstar_trig), .ain_valid(ain_valid), .ain_data(ain_data),
    .trig_level(trig_level), .trig_pulse(trig_pulse), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && trig_pulse) pulse_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_idle(input logic p);
    ext_trig = p; bus_in = {8{p}}; star_trig = p; dstar_trig = p;
  endtask

  task automatic setup(input logic [3:0] s, input logic p, input logic [1:0] ch,
                       input logic [2:0] ln, input logic m, input logic [2:0] d);
    @(negedge clk);
    arm = 0; src_sel = s; falling_edge = p; ain_sel = ch; line_sel = ln;
    master_en = m; drive_sel = d; sw_strobe = 0; ain_valid = 0;
    set_idle(p);
    repeat (4) @(negedge clk);
    arm = 1;
    repeat (2) @(negedge clk);
    pulse_cnt = 0;
  endtask

  task automatic set_target(input logic [3:0] s, input logic [2:0] ln, input logic v);
    case (s)
      4'd1: ext_trig = v;
      4'd3: bus_in[ln] = v;
      4'd4: star_trig = v;
      4'd5: dstar_trig = v;
      default: begin ext_trig = v; bus_in = {8{v}}; star_trig = v; dstar_trig = v; end
    endcase
  endtask

  task automatic pulse_line(input logic [3:0] s, input logic [2:0] ln, input logic p, input int len);
    @(negedge clk);
    set_target(s, ln, ~p);
    repeat (len) @(negedge clk);
    set_target(s, ln, p);
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic signed [15:0] c0, c1, c2, c3, output logic fired);
    @(negedge clk);
    ain_data = {c3, c2, c1, c0};
    ain_valid = 1;
    @(negedge clk);
    fired = trig_pulse;
    ain_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic f;
    repeat (3) @(negedge clk);
    chk("R1 trig_pulse in reset", trig_pulse, 0);
    chk("R1 bus_out in reset", bus_out, 0);
    chk("R1 bus_oe in reset", bus_oe, 0);
    rst_n = 1;

    // Vector table: digital sources, polarity, width, unused codes
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      string tag;
      v = VEC[i];
      setup(v[15:12], v[11], 2'd0, v[10:8], 1'b0, 3'd0);
      pulse_line(v[15:12], v[10:8], v[11], int'(v[7:4]));
      if (v[3:0] == 0) tag = (v[15:12] > 4'd5) ? "R2 unused code" : "R6 short pulse";
      else if (v[15:12] inside {4'd3, 4'd4, 4'd5}) tag = "R13 bus/star line";
      else tag = v[11] ? "R5 falling" : "R4 rising";
      chk($sformatf("%s vector %0d", tag, i), pulse_cnt, int'(v[3:0]));
    end

    // R4 latency and R7 single pulse for a long level
    setup(4'd1, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0);
    @(negedge clk); ext_trig = 1;
    repeat (3) @(negedge clk);
    chk("R4 latency not yet", trig_pulse, 0);
    @(negedge clk);
    chk("R4 latency fourth cycle", trig_pulse, 1);
    @(negedge clk);
    chk("R7 pulse one cycle", trig_pulse, 0);
    repeat (10) @(negedge clk);
    chk("R7 long level one pulse", pulse_cnt, 1);
    ext_trig = 0;

    // R6 active level at arming
    setup(4'd1, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0);
    arm = 0; ext_trig = 1;
    repeat (4) @(negedge clk);
    arm = 1;
    repeat (10) @(negedge clk);
    chk("R6 active at arming", pulse_cnt, 0);
    ext_trig = 0;
    repeat (4) @(negedge clk);
    pulse_line(4'd1, 3'd0, 1'b0, 3);
    chk("R6 after idle", pulse_cnt, 1);

    // R3 software strobe
    setup(4'd0, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0);
    sw_strobe = 1;
    @(negedge clk);
    chk("R3 strobe pulse", trig_pulse, 1);
    @(negedge clk);
    chk("R3 strobe ends", trig_pulse, 0);
    repeat (3) @(negedge clk);
    sw_strobe = 0;
    repeat (2) @(negedge clk);
    chk("R3 held strobe count", pulse_cnt, 1);

    // R11 master drive, same cycle as trigger
    setup(4'd0, 1'b0, 2'd0, 3'd0, 1'b1, 3'd6);
    chk("R11 oe bit", bus_oe, 8'h40);
    sw_strobe = 1;
    @(negedge clk);
    chk("R11 bus_out with trigger", bus_out, 8'h40);
    @(negedge clk);
    chk("R11 bus_out after trigger", bus_out, 8'h00);
    sw_strobe = 0;
    setup(4'd0, 1'b0, 2'd0, 3'd0, 1'b0, 3'd6);
    chk("R11 oe off", bus_oe, 8'h00);
    sw_strobe = 1;
    @(negedge clk);
    chk("R11 no drive without master", bus_out, 8'h00);
    sw_strobe = 0;

    // R8 analog rising on channel 2, other channels toggling
    trig_level = 16'sd100;
    setup(4'd2, 1'b0, 2'd2, 3'd0, 1'b0, 3'd0);
    send(-500, 0, 50, 0, f);  chk("R8 first sample", f, 0);
    send(500, 0, 99, 0, f);   chk("R8 below", f, 0);
    send(-500, 0, 100, 0, f); chk("R8 crossing at level", f, 1);
    send(500, 0, 150, 0, f);  chk("R8 stays above", f, 0);
    send(-500, 0, 50, 0, f);  chk("R8 falls, rising mode", f, 0);

    // R9 analog falling, signed compare
    trig_level = 16'sd0;
    setup(4'd2, 1'b1, 2'd1, 3'd0, 1'b0, 3'd0);
    send(0, 5, 0, 0, f);  chk("R9 first sample", f, 0);
    send(0, -5, 0, 0, f); chk("R9 signed falling crossing", f, 1);
    send(0, -5, 0, 0, f); chk("R9 stays below", f, 0);

    // R10 samples while disarmed not remembered
    trig_level = 16'sd100;
    setup(4'd2, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0);
    arm = 0;
    send(0, 0, 0, 0, f);
    arm = 1;
    @(negedge clk);
    send(200, 0, 0, 0, f); chk("R10 first armed sample", f, 0);
    send(50, 0, 0, 0, f);  chk("R10 drop", f, 0);
    send(150, 0, 0, 0, f); chk("R10 later crossing", f, 1);

    // R12 source change while armed, and disarmed silence
    setup(4'd1, 1'b0, 2'd0, 3'd0, 1'b0, 3'd0);
    src_sel = 4'd4;
    pulse_line(4'd4, 3'd0, 1'b0, 3);
    chk("R12 new source ignored while armed", pulse_cnt, 0);
    pulse_line(4'd1, 3'd0, 1'b0, 3);
    chk("R12 frozen source still fires", pulse_cnt, 1);
    arm = 0;
    pulse_cnt = 0;
    pulse_line(4'd4, 3'd0, 1'b0, 3);
    pulse_line(4'd1, 3'd0, 1'b0, 3);
    chk("R12 disarmed silent", pulse_cnt, 0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule